// File: doc/BRIEF.md
# Legacy Display Range Router

This block classifies each access a host bridge sees against the fixed legacy display windows and names the side that should take it: the PCI bus or the dedicated graphics port. A request carries an address and a flag that tells memory space from I/O space. One clock after a valid request, the block gives a registered verdict. The verdict is graphics port, PCI, or "not legacy". On "not legacy", a downstream programmable window comparator decides instead.

Three plain configuration inputs steer the verdict. One enables the colour display window. One splits the monochrome sub-range away from it. One says whether a graphics-port device is present at all. When the monochrome split is active, a monochrome adapter on the PCI side and a colour adapter on the graphics port can coexist. I/O decode looks only at the ten low address bits, so every alias repeated every 1 KiB of I/O space also hits.

Top module: `lvr_router`

## Requirements
- R1: While reset is asserted and on the first edge after it, `rsp_valid` is 0 and `rsp_route` is 2'b00.
- R2: `rsp_valid` at an edge equals `req_valid` at the previous edge; when `req_valid` was 0, `rsp_route` is 2'b00.
- R3: A memory request (`req_is_io`=0) hits the legacy window when its full address lies in A0000h..BFFFFh inclusive; any other memory address gives 2'b00.
- R4: An I/O request (`req_is_io`=1) hits when bits [9:0] lie in 3B0h..3BBh or 3C0h..3DFh inclusive; 3BCh..3BFh, 3AFh and 3E0h give 2'b00.
- R5: For I/O requests, address bits above bit 9 have no effect on the verdict.
- R6: Route codes are 2'b00 none, 2'b01 PCI, 2'b10 graphics port; 2'b11 never appears. A hit with colour enable and graphics-port enable both set, and not steered by R9, gives 2'b10.
- R7: With colour enable (`cfg_vga_en`) clear, every hit gives 2'b01.
- R8: With graphics-port enable (`cfg_gfx_en`) clear, every hit gives 2'b01.
- R9: With monochrome split (`cfg_mono_en`) and both enables set, memory B0000h..B7FFFh and I/O 3B0h..3BBh give 2'b01, while the rest of the window still gives 2'b10.
- R10: The space flag selects the decoder: a memory request at 3C0h and an I/O request whose low ten bits are 000h give 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_vga_en | input | 1 | Colour display window enable |
| cfg_mono_en | input | 1 | Monochrome range split to PCI |
| cfg_gfx_en | input | 1 | Graphics-port device present |
| rsp_valid | output | 1 | Verdict valid |
| rsp_route | output | 2 | Verdict: 00 none, 01 PCI, 10 graphics port |

## Verification
Every verdict is due exactly one clock after the cycle its request was presented. The configuration inputs are sampled together with the request. The bench changes inputs on the falling edge and holds them through one rising edge. It then reads `rsp_valid` and `rsp_route` on the following falling edge, where the single output register has just updated. It then drops `req_valid` for a cycle, so each verdict is isolated and no request's result can shadow another's.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'b00,
      ROUTE_PCI  = 2'b01,
      ROUTE_GFX  = 2'b10
   } route_e;

   localparam int LEGACY_IO_BITS = 10;

   localparam logic [19:0] VGA_MEM_LO  = 20'hA0000;
   localparam logic [19:0] VGA_MEM_HI  = 20'hBFFFF;
   localparam logic [19:0] MONO_MEM_LO = 20'hB0000;
   localparam logic [19:0] MONO_MEM_HI = 20'hB7FFF;

   localparam logic [9:0] MONO_IO_LO  = 10'h3B0;
   localparam logic [9:0] MONO_IO_HI  = 10'h3BB;
   localparam logic [9:0] COLOR_IO_LO = 10'h3C0;
   localparam logic [9:0] COLOR_IO_HI = 10'h3DF;
endpackage

// File: rtl/lvr_mem_match.sv
module lvr_mem_match #(
   parameter int ADDR_W     = 32,
   parameter bit PREFIX_CMP = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              win_hit,
   output logic              mono_hit
);
   import lvr_pkg::*;

   localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(VGA_MEM_LO);
   localparam logic [ADDR_W-1:0] WIN_HI  = ADDR_W'(VGA_MEM_HI);
   localparam logic [ADDR_W-1:0] MONO_LO = ADDR_W'(MONO_MEM_LO);
   localparam logic [ADDR_W-1:0] MONO_HI = ADDR_W'(MONO_MEM_HI);
   localparam logic [ADDR_W-1:0] WIN_SPAN  = WIN_HI - WIN_LO;
   localparam logic [ADDR_W-1:0] MONO_SPAN = MONO_HI - MONO_LO;

   if (ADDR_W < 20) begin : g_bad_width
      $error("lvr_mem_match: ADDR_W must cover the 1 MiB legacy space");
   end

   if (PREFIX_CMP) begin : g_prefix
      if (((WIN_SPAN + 1) & WIN_SPAN) != '0 || (WIN_LO & WIN_SPAN) != '0) begin : g_bad_win
         $error("lvr_mem_match: window not aligned for prefix compare");
      end
      if (((MONO_SPAN + 1) & MONO_SPAN) != '0 || (MONO_LO & MONO_SPAN) != '0) begin : g_bad_mono
         $error("lvr_mem_match: mono range not aligned for prefix compare");
      end
      always_comb begin
         win_hit  = (addr & ~WIN_SPAN)  == WIN_LO;
         mono_hit = (addr & ~MONO_SPAN) == MONO_LO;
      end
   end else begin : g_magnitude
      always_comb begin
         win_hit  = (addr >= WIN_LO)  && (addr <= WIN_HI);
         mono_hit = (addr >= MONO_LO) && (addr <= MONO_HI);
      end
   end
endmodule

// File: rtl/lvr_io_match.sv
module lvr_io_match #(
   parameter int IO_BITS = 10
) (
   input  logic [IO_BITS-1:0] port_lo,
   output logic               win_hit,
   output logic               mono_hit
);
   import lvr_pkg::*;

   if (IO_BITS != LEGACY_IO_BITS) begin : g_bad_bits
      $error("lvr_io_match: legacy I/O decode is exactly ten bits wide");
   end

   logic mono_r, color_r;

   always_comb begin
      mono_r   = (port_lo >= MONO_IO_LO)  && (port_lo <= MONO_IO_HI);
      color_r  = (port_lo >= COLOR_IO_LO) && (port_lo <= COLOR_IO_HI);
      win_hit  = mono_r || color_r;
      mono_hit = mono_r;
   end
endmodule

// File: rtl/lvr_route_sel.sv
module lvr_route_sel (
   input  logic              hit,
   input  logic              mono_hit,
   input  logic              vga_en,
   input  logic              mono_en,
   input  logic              gfx_en,
   output lvr_pkg::route_e   route
);
   import lvr_pkg::*;

   logic to_gfx;

   always_comb begin
      to_gfx = vga_en && gfx_en && !(mono_en && mono_hit);
      if (!hit)       route = ROUTE_NONE;
      else if (to_gfx) route = ROUTE_GFX;
      else            route = ROUTE_PCI;
   end
endmodule

// File: rtl/lvr_router.sv
module lvr_router #(
   parameter int ADDR_W         = 32,
   parameter bit MEM_PREFIX_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_is_io,
   input  logic              cfg_vga_en,
   input  logic              cfg_mono_en,
   input  logic              cfg_gfx_en,
   output logic              rsp_valid,
   output logic [1:0]        rsp_route
);
   import lvr_pkg::*;

   localparam int IO_BITS = LEGACY_IO_BITS;

   logic    mem_win, mem_mono, io_win, io_mono;
   logic    any_hit, any_mono;
   route_e  route_d;

   lvr_mem_match #(
      .ADDR_W     (ADDR_W),
      .PREFIX_CMP (MEM_PREFIX_CMP)
   ) u_mem (
      .addr     (req_addr),
      .win_hit  (mem_win),
      .mono_hit (mem_mono)
   );

   lvr_io_match #(
      .IO_BITS (IO_BITS)
   ) u_io (
      .port_lo  (req_addr[IO_BITS-1:0]),
      .win_hit  (io_win),
      .mono_hit (io_mono)
   );

   always_comb begin
      any_hit  = req_is_io ? io_win  : mem_win;
      any_mono = req_is_io ? io_mono : mem_mono;
   end

   lvr_route_sel u_sel (
      .hit      (any_hit),
      .mono_hit (any_mono),
      .vga_en   (cfg_vga_en),
      .mono_en  (cfg_mono_en),
      .gfx_en   (cfg_gfx_en),
      .route    (route_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_route <= ROUTE_NONE;
      end else begin
         rsp_valid <= req_valid;
         rsp_route <= req_valid ? route_d : ROUTE_NONE;
      end
   end
endmodule

// File: rtl/lvr_router_chk.sv
module lvr_router_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_is_io,
   input logic              cfg_vga_en,
   input logic              cfg_mono_en,
   input logic              cfg_gfx_en,
   input logic              rsp_valid,
   input logic [1:0]        rsp_route
);
   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_route == 2'b00));

   assert_below_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io && req_addr < ADDR_W'(20'hA0000)) |=> rsp_route == 2'b00);

   assert_color_port_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_io && req_addr[9:0] == 10'h3D4) |=> rsp_route != 2'b00);

   assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_route != 2'b11);

   assert_no_gfx_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_vga_en) |=> rsp_route != 2'b10);

   assert_no_gfx_without_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_gfx_en) |=> rsp_route != 2'b10);

   assert_mono_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cfg_mono_en && req_is_io && req_addr[9:0] == 10'h3B4) |=> rsp_route == 2'b01);
endmodule

bind lvr_router lvr_router_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_is_io   (req_is_io),
   .cfg_vga_en  (cfg_vga_en),
   .cfg_mono_en (cfg_mono_en),
   .cfg_gfx_en  (cfg_gfx_en),
   .rsp_valid   (rsp_valid),
   .rsp_route   (rsp_route)
);

// File: tb/lvr_router_bench.sv
`timescale 1ns/1ps
module lvr_router_bench;
   localparam int ADDR_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_is_io = 1'b0;
   logic              cfg_vga_en = 1'b0;
   logic              cfg_mono_en = 1'b0;
   logic              cfg_gfx_en = 1'b0;
   logic              rsp_valid;
   logic [1:0]        rsp_route;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   lvr_router #(.ADDR_W(ADDR_W)) u_lvr_router (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_is_io(req_is_io), .cfg_vga_en(cfg_vga_en), .cfg_mono_en(cfg_mono_en),
      .cfg_gfx_en(cfg_gfx_en), .rsp_valid(rsp_valid), .rsp_route(rsp_route)
   );

   function automatic logic [1:0] expect_route(logic [ADDR_W-1:0] a, logic io,
                                                logic v, logic m, logic g);
      logic hit, mono;
      if (io) begin
         hit  = (a[9:0] >= 10'h3B0 && a[9:0] <= 10'h3BB) ||
                (a[9:0] >= 10'h3C0 && a[9:0] <= 10'h3DF);
         mono = (a[9:0] >= 10'h3B0 && a[9:0] <= 10'h3BB);
      end else begin
         hit  = (a >= 32'hA0000 && a <= 32'hBFFFF);
         mono = (a >= 32'hB0000 && a <= 32'hB7FFF);
      end
      if (!hit) return 2'b00;
      if (v && g && !(m && mono)) return 2'b10;
      return 2'b01;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(logic v, logic m, logic g);
      @(negedge clk);
      cfg_vga_en = v; cfg_mono_en = m; cfg_gfx_en = g;
   endtask

   task automatic probe(string tag, logic [ADDR_W-1:0] a, logic io);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_is_io = io;
      @(negedge clk);
      check({tag, " valid"}, 32'(rsp_valid), 32'd1);
      check(tag, 32'(rsp_route),
            32'(expect_route(a, io, cfg_vga_en, cfg_mono_en, cfg_gfx_en)));
      req_valid = 1'b0;
      @(negedge clk);
      check("R2 idle", {30'd0, rsp_route} | 32'(rsp_valid) << 8, 32'd0);
   endtask

   task automatic t_reset_R1;
      @(negedge clk);
      check("R1 valid in reset", 32'(rsp_valid), 32'd0);
      check("R1 route in reset", 32'(rsp_route), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", 32'(rsp_valid), 32'd0);
      check("R1 route after reset", 32'(rsp_route), 32'd0);
   endtask

   task automatic t_mem_R3;
      set_cfg(1, 0, 1);
      probe("R3 A0000", 32'hA0000, 0);
      probe("R3 BFFFF", 32'hBFFFF, 0);
      probe("R3 9FFFF", 32'h9FFFF, 0);
      probe("R3 C0000", 32'hC0000, 0);
      probe("R3 high alias", 32'h100A0000, 0);
      check("R6 window to gfx", 32'(expect_route(32'hA8000, 0, 1, 0, 1)), 32'd2);
   endtask

   task automatic t_io_R4;
      set_cfg(1, 0, 1);
      probe("R4 3B0", 32'h3B0, 1);
      probe("R4 3BB", 32'h3BB, 1);
      probe("R4 3BC", 32'h3BC, 1);
      probe("R4 3BF", 32'h3BF, 1);
      probe("R4 3AF", 32'h3AF, 1);
      probe("R4 3C0", 32'h3C0, 1);
      probe("R4 3DF", 32'h3DF, 1);
      probe("R4 3E0", 32'h3E0, 1);
   endtask

   task automatic t_alias_R5;
      set_cfg(1, 0, 1);
      probe("R5 alias 7BD4", 32'h7BD4, 1);
      probe("R5 alias FFD4", 32'hFFD4, 1);
      probe("R5 alias 123B5", 32'h123B5, 1);
      probe("R5 alias miss 0BE0", 32'h0BE0, 1);
   endtask

   task automatic t_vga_off_R7;
      set_cfg(0, 0, 1);
      probe("R7 mem", 32'hA4000, 0);
      probe("R7 io", 32'h3D5, 1);
      set_cfg(0, 1, 1);
      probe("R7 mono mem", 32'hB1000, 0);
   endtask

   task automatic t_gfx_off_R8;
      set_cfg(1, 0, 0);
      probe("R8 mem", 32'hB8000, 0);
      probe("R8 io", 32'h3C4, 1);
   endtask

   task automatic t_mono_R9;
      set_cfg(1, 1, 1);
      probe("R9 mono mem lo", 32'hB0000, 0);
      probe("R9 mono mem hi", 32'hB7FFF, 0);
      probe("R9 color mem", 32'hB8000, 0);
      probe("R9 graphics mem", 32'hA0000, 0);
      probe("R9 mono io", 32'h3B4, 1);
      probe("R9 color io", 32'h3D4, 1);
      probe("R9 mono io alias", 32'h0FBA, 1);
   endtask

   task automatic t_space_R10;
      set_cfg(1, 0, 1);
      probe("R10 mem at 3C0", 32'h3C0, 0);
      probe("R10 io at A0000", 32'hA0000, 1);
      check("R10 model io A0000", 32'(expect_route(32'hA0000, 1, 1, 0, 1)), 32'd0);
   endtask

   task automatic t_b2b_R2;
      set_cfg(1, 0, 1);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h3C8; req_is_io = 1'b1;
      @(negedge clk);
      check("R2 b2b first", 32'(rsp_route), 32'd2);
      req_addr = 32'h500; req_is_io = 1'b1;
      @(negedge clk);
      check("R2 b2b second", 32'(rsp_route), 32'd0);
      check("R2 b2b valid", 32'(rsp_valid), 32'd1);
      req_valid = 1'b0;
      @(negedge clk);
      check("R2 b2b drop", 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset_R1();
      t_mem_R3();
      t_io_R4();
      t_alias_R5();
      t_vga_off_R7();
      t_gfx_off_R8();
      t_mono_R9();
      t_space_R10();
      t_b2b_R2();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule